// File: doc/BRIEF.md
# Multi-Format Stereo Serial Transmitter

This block turns a pair of parallel audio samples into a single serial data line. It does not generate the serial clocks itself. An external bit clock and an external frame clock arrive as plain inputs and are sampled by the fast system clock. The transmitter moves its data line one system-clock cycle after each falling edge of the bit clock. Each channel occupies a half-frame of 32 bit periods, and words are sent most significant bit first.

Four frame alignments share one slot counter and one bit selector:

- **I2S:** the word starts one period after the frame-clock edge.
- **Left-justified:** the word starts right at the frame-clock edge.
- **Right-justified:** the last bit of the word ends the half-frame.
- **Pulse-sync:** a rising frame-clock pulse opens a frame. The left word is followed at once by the right word, and the frame-clock level says nothing about the channel.

Word length runs from 16 to 24 bits. The sample inputs are taken MSB-aligned, so a shorter word uses the upper bits of the sample bus. The samples, the format and the word length are captured when a frame starts. Any bit period that carries no word bit is driven low.

Top module: `audtx_stereo_ser`

## Requirements
- R1: After reset, and until the first frame start, the serial output is low.
- R2: The serial output changes only in the system-clock cycle that follows a falling edge of the bit clock, and it holds steady for the rest of the bit period.
- R3: With format code 2'b00 (I2S), a falling frame-clock edge starts the frame. The left word is sent while the frame clock is low, the right word while it is high. Each word's MSB goes out in the second bit period of its half-frame, and the first period is low.
- R4: With format code 2'b01 (left-justified), a rising frame-clock edge starts the frame. The left word is sent while the frame clock is high. Each MSB goes out in the first bit period after the frame-clock edge.
- R5: With format code 2'b10 (right-justified), a rising frame-clock edge starts the frame and the left word is sent while the frame clock is high. The word's LSB goes out in bit period 31 of its half-frame, and the periods before the MSB are low.
- R6: With format code 2'b11 (pulse-sync), a rising frame-clock edge starts the frame and the left MSB goes out in the first period. The right MSB follows directly after the left LSB. A falling frame-clock edge restarts nothing, whatever the pulse width.
- R7: The word-length input is 5 bits wide. Values below 16 act as 16 and values above 24 act as 24. The word is always taken from the top bits of the 24-bit sample, with bit 23 as the MSB.
- R8: The left sample, the right sample and the word length are captured at the frame start. Changes to these inputs later in the frame do not alter the bits sent in that frame.
- R9: In pulse-sync format the slot count stops at period 63. Any further bit periods before the next frame start are driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | External bit clock |
| fclk_i | input | 1 | External frame clock |
| fmt_i | input | 2 | Format: 00 I2S, 01 left-justified, 10 right-justified, 11 pulse-sync |
| wlen_i | input | 5 | Word length in bits, clamped to 16..24 |
| left_i | input | 24 | Left sample, MSB at bit 23 |
| right_i | input | 24 | Right sample, MSB at bit 23 |
| sdata_o | output | 1 | Serial data, registered |

## Verification
The assertions assume the following about the inputs:

- Both clock inputs are synchronous to the system clock.
- Each bit-clock phase lasts at least two system-clock cycles.
- The frame clock moves only together with a falling bit-clock edge.
- The format select stays fixed within a frame.

The stimulus keeps within these assumptions. It drives every input on the falling system-clock edge, and it gives the bit clock four-cycle low and high phases. It changes the frame clock only in the same cycle as the bit-clock fall. It changes the format only between frame pairs, and each pair begins with a discarded priming frame.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  function automatic int clamp_len(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/audtx_clk_edge.sv
module audtx_clk_edge
  import audtx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic fclk_i,
  input  fmt_e fmt_live,
  input  fmt_e fmt_held,
  output logic bit_tick,
  output logic frame_start,
  output logic restart
);

  logic bclk_q;
  logic fclk_q;
  logic changed;
  logic start_dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= 1'b0;
      fclk_q <= 1'b0;
    end else begin
      bclk_q <= bclk_i;
      if (bit_tick) fclk_q <= fclk_i;
    end
  end

  always_comb begin
    bit_tick    = bclk_q & ~bclk_i;
    changed     = fclk_i ^ fclk_q;
    // I2S opens its frame on the falling frame-clock edge, all others on the rising edge
    start_dir   = (fmt_live == FMT_I2S) ? ~fclk_i : fclk_i;
    frame_start = bit_tick & changed & start_dir;
    // the half-frame boundary restarts the count except in pulse-sync mode
    restart     = frame_start | (bit_tick & changed & (fmt_held != FMT_DSP));
  end

  AST_DSP_FALL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && fmt_held == FMT_DSP && fmt_live == FMT_DSP && !fclk_i) |-> !restart); // R6

endmodule

// File: rtl/audtx_slot_cnt.sv
module audtx_slot_cnt #(
  parameter int HALF = 32,
  localparam int SLOTS = 2 * HALF,
  localparam int CW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_tick,
  input  logic          restart,
  output logic [CW-1:0] cnt_nxt
);

  localparam logic [CW-1:0] TOP = CW'(SLOTS - 1);

  logic [CW-1:0] cnt;

  always_comb begin
    if (restart)         cnt_nxt = '0;
    else if (cnt == TOP) cnt_nxt = TOP;
    else                 cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt <= TOP;
    else if (bit_tick) cnt <= cnt_nxt;
  end

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && !restart && cnt == TOP) |=> (cnt == TOP)); // R9
  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && !restart && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1)); // R2
  AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(cnt)); // R2

endmodule

// File: rtl/audtx_frame_latch.sv
module audtx_frame_latch
  import audtx_pkg::*;
#(
  parameter int SW = 24,
  parameter int MINL = 16,
  localparam int LW = $clog2(SW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  fmt_e          fmt_live,
  input  logic [LW-1:0] wlen_i,
  input  logic [SW-1:0] left_i,
  input  logic [SW-1:0] right_i,
  output fmt_e          fmt_held,
  output fmt_e          fmt_eff,
  output logic [LW-1:0] len_eff,
  output logic [SW-1:0] left_eff,
  output logic [SW-1:0] right_eff
);

  fmt_e          fmt_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] len_live;
  logic [SW-1:0] left_q;
  logic [SW-1:0] right_q;

  always_comb len_live = LW'(clamp_len(int'(wlen_i), MINL, SW));

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q   <= FMT_I2S;
      len_q   <= LW'(SW);
      left_q  <= '0;
      right_q <= '0;
    end else if (frame_start) begin
      fmt_q   <= fmt_live;
      len_q   <= len_live;
      left_q  <= left_i;
      right_q <= right_i;
    end
  end

  // at the starting edge itself the fresh values are needed for bit 0
  always_comb begin
    fmt_held  = fmt_q;
    fmt_eff   = frame_start ? fmt_live : fmt_q;
    len_eff   = frame_start ? len_live : len_q;
    left_eff  = frame_start ? left_i   : left_q;
    right_eff = frame_start ? right_i  : right_q;
  end

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(len_q) >= MINL) && (int'(len_q) <= SW)); // R7
  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(left_q) && $stable(right_q) && $stable(len_q))); // R8

endmodule

// File: rtl/audtx_bit_sel.sv
module audtx_bit_sel
  import audtx_pkg::*;
#(
  parameter int SW = 24,
  parameter int HALF = 32,
  localparam int CW = $clog2(2 * HALF),
  localparam int LW = $clog2(SW + 1),
  localparam int IW = $clog2(SW)
) (
  input  fmt_e          fmt,
  input  logic [LW-1:0] len,
  input  logic [CW-1:0] slot,
  input  logic          fclk_lvl,
  input  logic [SW-1:0] left_w,
  input  logic [SW-1:0] right_w,
  output logic          bit_o
);

  int            k;
  int            n;
  int            j;
  logic          valid;
  logic          use_left;
  logic [IW-1:0] idx;
  logic [SW-1:0] word;

  always_comb begin
    k        = int'(slot);
    n        = int'(len);
    j        = 0;
    valid    = 1'b0;
    // channel from the frame-clock level: I2S is left while low, the others while high
    use_left = (fmt == FMT_I2S) ? ~fclk_lvl : fclk_lvl;
    case (fmt)
      FMT_I2S: begin
        if (k >= 1 && k <= n) begin
          valid = 1'b1;
          j     = k - 1;
        end
      end
      FMT_LJ: begin
        if (k < n) begin
          valid = 1'b1;
          j     = k;
        end
      end
      FMT_RJ: begin
        if (k >= HALF - n && k < HALF) begin
          valid = 1'b1;
          j     = k - (HALF - n);
        end
      end
      default: begin
        // pulse-sync: left word then right word, back to back
        if (k < n) begin
          valid    = 1'b1;
          use_left = 1'b1;
          j        = k;
        end else if (k < 2 * n) begin
          valid    = 1'b1;
          use_left = 1'b0;
          j        = k - n;
        end
      end
    endcase
    idx   = IW'(SW - 1 - j);
    word  = use_left ? left_w : right_w;
    bit_o = valid & word[idx];
  end

endmodule

// File: rtl/audtx_stereo_ser.sv
module audtx_stereo_ser
  import audtx_pkg::*;
#(
  parameter int SW = 24,
  parameter int HALF = 32,
  parameter int MINL = 16,
  localparam int CW = $clog2(2 * HALF),
  localparam int LW = $clog2(SW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bclk_i,
  input  logic          fclk_i,
  input  logic [1:0]    fmt_i,
  input  logic [LW-1:0] wlen_i,
  input  logic [SW-1:0] left_i,
  input  logic [SW-1:0] right_i,
  output logic          sdata_o
);

  localparam logic [CW-1:0] TOP = CW'(2 * HALF - 1);

  fmt_e          fmt_live;
  fmt_e          fmt_held;
  fmt_e          fmt_eff;
  logic          bit_tick;
  logic          frame_start;
  logic          restart;
  logic [CW-1:0] cnt_nxt;
  logic [LW-1:0] len_eff;
  logic [SW-1:0] left_eff;
  logic [SW-1:0] right_eff;
  logic          bit_val;

  always_comb fmt_live = fmt_e'(fmt_i);

  audtx_clk_edge u_edge (
    .clk         (clk),
    .rst         (rst),
    .bclk_i      (bclk_i),
    .fclk_i      (fclk_i),
    .fmt_live    (fmt_live),
    .fmt_held    (fmt_held),
    .bit_tick    (bit_tick),
    .frame_start (frame_start),
    .restart     (restart)
  );

  audtx_slot_cnt #(.HALF(HALF)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .restart  (restart),
    .cnt_nxt  (cnt_nxt)
  );

  audtx_frame_latch #(.SW(SW), .MINL(MINL)) u_latch (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .fmt_live    (fmt_live),
    .wlen_i      (wlen_i),
    .left_i      (left_i),
    .right_i     (right_i),
    .fmt_held    (fmt_held),
    .fmt_eff     (fmt_eff),
    .len_eff     (len_eff),
    .left_eff    (left_eff),
    .right_eff   (right_eff)
  );

  audtx_bit_sel #(.SW(SW), .HALF(HALF)) u_sel (
    .fmt      (fmt_eff),
    .len      (len_eff),
    .slot     (cnt_nxt),
    .fclk_lvl (fclk_i),
    .left_w   (left_eff),
    .right_w  (right_eff),
    .bit_o    (bit_val)
  );

  always_ff @(posedge clk) begin
    if (rst)           sdata_o <= 1'b0;
    else if (bit_tick) sdata_o <= bit_val;
  end

  AST_SDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(sdata_o)); // R2
  AST_I2S_GAP_LOW: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && restart && fmt_eff == FMT_I2S) |=> !sdata_o); // R3
  AST_RJ_LEAD_LOW: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && restart && fmt_eff == FMT_RJ) |=> !sdata_o); // R5
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && cnt_nxt == TOP) |=> !sdata_o); // R9

endmodule

// File: tb/sim_audtx_stereo_ser.sv
`timescale 1ns/1ps
module sim_audtx_stereo_ser;

  localparam int SW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bclk_i = 1'b1;
  logic          fclk_i = 1'b0;
  logic [1:0]    fmt_i = 2'b00;
  logic [4:0]    wlen_i = 5'd24;
  logic [SW-1:0] left_i = '0;
  logic [SW-1:0] right_i = '0;
  logic          sdata_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic got_bit [0:71];
  int   unstable;

  always #2 clk = ~clk;

  audtx_stereo_ser u0 (
    .clk(clk), .rst(rst), .bclk_i(bclk_i), .fclk_i(fclk_i), .fmt_i(fmt_i),
    .wlen_i(wlen_i), .left_i(left_i), .right_i(right_i), .sdata_o(sdata_o)
  );

  function automatic int clamp(input int v);
    if (v < 16) return 16;
    if (v > 24) return 24;
    return v;
  endfunction

  // expected bit for slot k of a half-frame (or of a pulse-sync frame)
  function automatic logic exp_bit(input int fmt, input int len, input int k, input bit lch,
                                   input logic [SW-1:0] l, input logic [SW-1:0] r);
    int p;
    logic [SW-1:0] w;
    w = lch ? l : r;
    p = -1;
    if (fmt == 0 && k >= 1 && k <= len) p = k - 1;
    if (fmt == 1 && k < len) p = k;
    if (fmt == 2 && k >= 32 - len && k < 32) p = k - (32 - len);
    if (fmt == 3) begin
      if (k < len) begin p = k; w = l; end
      else if (k < 2 * len) begin p = k - len; w = r; end
    end
    if (p < 0) return 1'b0;
    return w[SW-1-p];
  endfunction

  // one bit period: 4 clk low, 4 clk high; samples in each phase
  task automatic bit_period(input logic lvl, output logic b);
    logic s1;
    @(negedge clk);
    bclk_i = 1'b0;
    fclk_i = lvl;
    repeat (3) @(negedge clk);
    s1 = sdata_o;
    @(negedge clk);
    bclk_i = 1'b1;
    repeat (3) @(negedge clk);
    b = sdata_o;
    if (s1 !== b) unstable++;
  endtask

  function automatic logic lvl_of(input int fmt, input int s, input int pw);
    if (fmt == 3) return (s < pw);
    if (fmt == 0) return (s >= 32);
    return (s < 32);
  endfunction

  task automatic play_frame(input int fmt, input int pw, input int ns, input bit mid);
    logic b;
    for (int s = 0; s < ns; s++) begin
      if (mid && s == 4) begin
        left_i  = left_i ^ 24'h5A5A5A;
        right_i = right_i ^ 24'hA5A5A5;
        wlen_i  = 5'd16;
      end
      bit_period(lvl_of(fmt, s, pw), b);
      got_bit[s] = b;
    end
  endtask

  task automatic run_pair(input string req, input string name, input int fmt, input int wlen,
                          input logic [SW-1:0] l, input logic [SW-1:0] r,
                          input int pw, input int ns, input bit mid);
    int bad;
    int first;
    logic e;
    logic g0;
    logic e0;
    int len;
    fmt_i   = 2'(fmt);
    wlen_i  = 5'(wlen);
    left_i  = ~l;
    right_i = ~r;
    play_frame(fmt, pw, 64, 1'b0);
    left_i  = l;
    right_i = r;
    unstable = 0;
    play_frame(fmt, pw, ns, mid);
    len = clamp(wlen);
    bad = 0;
    first = -1;
    g0 = 1'b0;
    e0 = 1'b0;
    for (int s = 0; s < ns; s++) begin
      if (fmt == 3) e = exp_bit(3, len, (s > 63) ? 63 : s, 1'b1, l, r);
      else e = exp_bit(fmt, len, s % 32, (s < 32), l, r);
      if (got_bit[s] !== e) begin
        if (first < 0) begin first = s; g0 = got_bit[s]; e0 = e; end
        bad++;
      end
    end
    n_run++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s %s: slot %0d got %b exp %b (%0d bad slots)", req, name, first, g0, e0, bad);
    end
    n_run++;
    if (unstable != 0) begin
      n_fail++;
      $display("FAIL R2 %s: output moved within %0d bit periods, got %0d exp 0", name, unstable, unstable);
    end
  endtask

  task automatic test_reset();
    n_run++;
    if (sdata_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got %b exp 0", sdata_o);
    end
  endtask

  task automatic test_idle();
    logic b;
    int ones;
    ones = 0;
    left_i  = '1;
    right_i = '1;
    unstable = 0;
    for (int s = 0; s < 12; s++) begin
      bit_period(1'b0, b);
      if (b !== 1'b0) ones++;
    end
    n_run++;
    if (ones != 0) begin
      n_fail++;
      $display("FAIL R1 idle before frame: got %0d high periods exp 0", ones);
    end
  endtask

  task automatic test_i2s();
    run_pair("R3", "i2s len24", 0, 24, 24'hC3A511, 24'h5E0F81, 1, 64, 1'b0);
    run_pair("R3", "i2s len16", 0, 16, 24'hF00F3C, 24'h81A5FF, 1, 64, 1'b0);
  endtask

  task automatic test_lj();
    run_pair("R4", "lj len24", 1, 24, 24'hB1C2D3, 24'h123457, 1, 64, 1'b0);
    run_pair("R4", "lj len20", 1, 20, 24'hFFFFFF, 24'h800001, 1, 64, 1'b0);
  endtask

  task automatic test_rj();
    run_pair("R5", "rj len24", 2, 24, 24'h9ABCDF, 24'hE7180F, 1, 64, 1'b0);
    run_pair("R5", "rj len16", 2, 16, 24'hFFFF00, 24'hFFFFFF, 1, 64, 1'b0);
  endtask

  task automatic test_dsp();
    run_pair("R6", "dsp len24 pulse1", 3, 24, 24'hA1B2C3, 24'hFEDCBB, 1, 64, 1'b0);
    run_pair("R6", "dsp len16 pulse3", 3, 16, 24'hFFFF00, 24'hC0C0C0, 3, 64, 1'b0);
    run_pair("R9", "dsp long frame", 3, 24, 24'hFFFFFF, 24'hFFFFFF, 1, 70, 1'b0);
  endtask

  task automatic test_clamp();
    run_pair("R7", "len30 as 24", 1, 30, 24'hFFFFFF, 24'h7FFFFF, 1, 64, 1'b0);
    run_pair("R7", "len3 as 16", 2, 3, 24'hFFFFFF, 24'hFFFFFF, 1, 64, 1'b0);
  endtask

  task automatic test_latch();
    run_pair("R8", "mid-frame change", 1, 24, 24'h3C5AF1, 24'hC3A50F, 1, 64, 1'b1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    test_reset();
    test_idle();
    test_i2s();
    test_lj();
    test_rj();
    test_dsp();
    test_clamp();
    test_latch();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule